// File: doc/BRIEF.md
# UART Register Block with Status and Interrupt Logic

This block holds the software-visible registers of a simple serial port: an 8-slot word-addressed register window, the line-status and interrupt-identification flags, and one level interrupt line. A processor reaches it through a 32-bit slave bus that has separate read and write strobes, a byte offset and read and write data. Read data is combinational from the current register state, so it is valid in the same cycle as the read strobe. Write effects and read side effects take hold at the next rising clock edge.

Serialisation happens outside the block. A write to the data slot hands a character to a byte-stream output that uses valid/ready. The character is masked to the word length chosen in line control. Once the downstream serialiser has shifted the byte out, it returns a one-cycle completion pulse. Incoming bytes arrive on a byte-stream input. That input is ready only while the receive buffer is empty. An access to an offset outside the window sets a sticky error flag.

Top module: `uart_regif`

## Requirements
- R1: After reset every register reads zero, except line status at offset 0x14, which reads 0x20. After reset the interrupt, the transmit valid and the error flag are low, and receive ready is high.
- R2: The slots at 0x08 (identification), 0x0C (line control), 0x10 (modem control), 0x18 (modem status) and 0x1C (divisor) store the low 8 bits of a write. They read back with bits 31:8 zero.
- R3: A write to 0x00 stores the byte, clears line-status bit 5 and clears identification bit 1 (other bits are kept). From the next cycle, transmit valid is high.
- R4: The transmitted character is the stored byte ANDed with a mask chosen by line-control bits [1:0]. The masks are 0x1F for code 0, 0x3F for code 1, 0x7F for code 2 and 0xFF for code 3.
- R5: Transmit valid stays high until transmit ready is seen. The block then waits for the completion pulse. A completion pulse is ignored while no handed-off byte is outstanding.
- R6: When a transmission completes, line-status bit 5 is set and identification is loaded with 0x02. The interrupt is asserted if interrupt-enable bit 1 is set; otherwise it is left unchanged.
- R7: Writing 0x04 with bit 1 set while line-status bit 5 is set sets identification bit 1 and asserts the interrupt. Writing it with bit 1 clear deasserts the interrupt.
- R8: Receive ready equals the inverse of line-status bit 0. An accepted byte loads the receive buffer and sets line-status bit 0. If interrupt-enable bit 0 is set, identification becomes 0x04 and the interrupt is asserted.
- R9: A read of 0x00 returns the receive buffer and clears line-status bit 0.
- R10: A read or write at a misaligned offset or at an offset of 0x20 or more returns zero and changes no register. It also sets the error output, which stays high until reset.
- R11: A data write made while an earlier byte is still outstanding is held. It is offered after the earlier completion pulse. That pulse does not count as a completion, and line-status bit 5 stays clear until the held byte has also completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset into the register window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| bus_err | output | 1 | Sticky unmapped-access flag |
| tx_data | output | 8 | Masked outgoing character |
| tx_valid | output | 1 | Outgoing character offered |
| tx_ready | input | 1 | Downstream takes the character |
| tx_done | input | 1 | One-cycle pulse: character fully sent |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte offered |
| rx_ready | output | 1 | Receive buffer empty, byte will be taken |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check the following on every cycle:
- an offered transmit byte is never withdrawn before ready;
- an accepted receive byte always leaves line-status bit 0 set;
- the error flag never falls;
- line-status bit 5 only falls after a data or line-status write;
- every rising edge of the interrupt has one of its three causes in the previous cycle.

Only the directed scenarios can show the actual values involved: the masked characters for each word length, the identification codes, the immediate interrupt on enable, receive back-pressure, and the held second byte.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

    localparam int CHAR_W   = 8;
    localparam int NUM_SLOT = 8;
    localparam int SLOT_W   = $clog2(NUM_SLOT);

    // slot index = byte offset / 4
    localparam logic [SLOT_W-1:0] SL_DATA  = 3'd0;
    localparam logic [SLOT_W-1:0] SL_IEN   = 3'd1;
    localparam logic [SLOT_W-1:0] SL_IID   = 3'd2;
    localparam logic [SLOT_W-1:0] SL_LCTL  = 3'd3;
    localparam logic [SLOT_W-1:0] SL_MCTL  = 3'd4;
    localparam logic [SLOT_W-1:0] SL_LSTAT = 3'd5;
    localparam logic [SLOT_W-1:0] SL_MSTAT = 3'd6;
    localparam logic [SLOT_W-1:0] SL_DIV   = 3'd7;

    localparam int LS_RXAV = 0;
    localparam int LS_THRE = 5;
    localparam int IE_RX   = 0;
    localparam int IE_TX   = 1;
    localparam int ID_TXB  = 1;

    localparam logic [CHAR_W-1:0] ID_TX_CODE = 8'h02;
    localparam logic [CHAR_W-1:0] ID_RX_CODE = 8'h04;
    localparam logic [CHAR_W-1:0] LS_RESET   = 8'h20;

    typedef enum logic [1:0] {
        TXS_IDLE  = 2'd0,
        TXS_OFFER = 2'd1,
        TXS_WAIT  = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic [CHAR_W-1:0] rbuf;
        logic [CHAR_W-1:0] hold;
        logic [CHAR_W-1:0] ien;
        logic [CHAR_W-1:0] iid;
        logic [CHAR_W-1:0] lctl;
        logic [CHAR_W-1:0] mctl;
        logic [CHAR_W-1:0] lstat;
        logic [CHAR_W-1:0] mstat;
        logic [CHAR_W-1:0] div;
        logic              irq;
        logic              err;
    } regs_t;

    function automatic logic [CHAR_W-1:0] len_mask(input logic [1:0] code);
        case (code)
            2'd0:    len_mask = 8'h1F;
            2'd1:    len_mask = 8'h3F;
            2'd2:    len_mask = 8'h7F;
            default: len_mask = 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/uart_addr_decode.sv
module uart_addr_decode
    import uart_regif_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic                hit,
    output logic [SLOT_W-1:0]   idx,
    output logic [NUM_SLOT-1:0] sel
);
    localparam int WIN_BITS = SLOT_W + 2;

    logic aligned;
    logic in_window;

    always_comb begin
        aligned   = (addr[1:0] == 2'b00);
        in_window = ((addr >> WIN_BITS) == '0);
        hit       = aligned && in_window;
        idx       = addr[WIN_BITS-1:2];
    end

    for (genvar g = 0; g < NUM_SLOT; g++) begin : g_sel
        assign sel[g] = hit && (idx == SLOT_W'(g));
    end

endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
    import uart_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CHAR_W-1:0] char_in,
    output logic [CHAR_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic              tx_done,
    output logic              complete
);
    typedef struct packed {
        tx_state_e st;
        logic      pend;
    } txr_t;

    txr_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        complete = 1'b0;
        case (s_q.st)
            TXS_IDLE: begin
                if (start) s_d.st = TXS_OFFER;
            end
            TXS_OFFER: begin
                if (tx_ready) begin
                    s_d.st   = TXS_WAIT;
                    s_d.pend = start;
                end
            end
            TXS_WAIT: begin
                if (start) s_d.pend = 1'b1;
                if (tx_done) begin
                    if (s_q.pend || start) begin
                        s_d.st   = TXS_OFFER;
                        s_d.pend = 1'b0;
                    end else begin
                        s_d.st   = TXS_IDLE;
                        complete = 1'b1;
                    end
                end
            end
            default: s_d.st = TXS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: TXS_IDLE, pend: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_valid = (s_q.st == TXS_OFFER);
    assign tx_data  = char_in;

    // R5: an offered byte is not withdrawn before ready
    p_valid_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> tx_valid);

    // R11: a byte held behind an outstanding one is offered after the pulse
    p_pend_offer_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == TXS_WAIT && s_q.pend && tx_done) |=> tx_valid);

endmodule

// File: rtl/uart_regif.sv
module uart_regif
    import uart_regif_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic              tx_done,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic              irq
);
    localparam int PAD_W = DATA_W - CHAR_W;

    regs_t r_d, r_q;

    logic                hit;
    logic [SLOT_W-1:0]   idx;
    logic [NUM_SLOT-1:0] sel;
    logic                tx_start;
    logic                tx_complete;
    logic                rx_take;
    logic [CHAR_W-1:0]   wbyte;
    logic [CHAR_W-1:0]   rbyte;
    logic [PAD_W-1:0]    unused_wdata_hi;

    assign wbyte           = bus_wdata[CHAR_W-1:0];
    assign unused_wdata_hi = bus_wdata[DATA_W-1:CHAR_W];

    uart_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .hit  (hit),
        .idx  (idx),
        .sel  (sel)
    );

    assign tx_start = bus_wr && sel[SL_DATA];

    uart_tx_path u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (tx_start),
        .char_in  (r_q.hold & len_mask(r_q.lctl[1:0])),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .tx_done  (tx_done),
        .complete (tx_complete)
    );

    assign rx_ready = ~r_q.lstat[LS_RXAV];
    assign rx_take  = rx_valid && rx_ready;

    // read mux: current state, zero outside the window
    always_comb begin
        rbyte = '0;
        if (hit) begin
            case (idx)
                SL_DATA:  rbyte = r_q.rbuf;
                SL_IEN:   rbyte = r_q.ien;
                SL_IID:   rbyte = r_q.iid;
                SL_LCTL:  rbyte = r_q.lctl;
                SL_MCTL:  rbyte = r_q.mctl;
                SL_LSTAT: rbyte = r_q.lstat;
                SL_MSTAT: rbyte = r_q.mstat;
                default:  rbyte = r_q.div;
            endcase
        end
    end

    assign bus_rdata = {{PAD_W{1'b0}}, rbyte};

    // next-state: bus effects first, hardware events override
    always_comb begin
        r_d = r_q;

        if ((bus_wr || bus_rd) && !hit) r_d.err = 1'b1;

        if (bus_wr) begin
            if (sel[SL_DATA]) begin
                r_d.hold           = wbyte;
                r_d.lstat[LS_THRE] = 1'b0;
                r_d.iid[ID_TXB]    = 1'b0;
            end
            if (sel[SL_IEN]) begin
                r_d.ien = wbyte;
                if (wbyte[IE_TX] && r_q.lstat[LS_THRE]) begin
                    r_d.iid[ID_TXB] = 1'b1;
                    r_d.irq         = 1'b1;
                end else if (!wbyte[IE_TX]) begin
                    r_d.irq = 1'b0;
                end
            end
            if (sel[SL_IID])   r_d.iid   = wbyte;
            if (sel[SL_LCTL])  r_d.lctl  = wbyte;
            if (sel[SL_MCTL])  r_d.mctl  = wbyte;
            if (sel[SL_LSTAT]) r_d.lstat = wbyte;
            if (sel[SL_MSTAT]) r_d.mstat = wbyte;
            if (sel[SL_DIV])   r_d.div   = wbyte;
        end

        if (bus_rd && sel[SL_DATA]) r_d.lstat[LS_RXAV] = 1'b0;

        if (tx_complete) begin
            r_d.lstat[LS_THRE] = 1'b1;
            r_d.iid            = ID_TX_CODE;
            if (r_q.ien[IE_TX]) r_d.irq = 1'b1;
        end

        if (rx_take) begin
            r_d.rbuf           = rx_data;
            r_d.lstat[LS_RXAV] = 1'b1;
            if (r_q.ien[IE_RX]) begin
                r_d.iid = ID_RX_CODE;
                r_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.lstat <= LS_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign irq     = r_q.irq;
    assign bus_err = r_q.err;

    // R8: an accepted byte always leaves the data-available flag set
    p_rx_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_take |=> r_q.lstat[LS_RXAV]);

    // R10: the error flag never falls
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> bus_err);

    // R3: holding-empty only falls after a data or line-status write
    p_thre_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.lstat[LS_THRE]) |-> $past(bus_wr && (sel[SL_DATA] || sel[SL_LSTAT])));

    // R6 / R7 / R8: every interrupt rise has a cause
    p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tx_complete || rx_take || (bus_wr && sel[SL_IEN])));

endmodule

// File: tb/tb_uart_regif.sv
module tb_uart_regif;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic        tx_done = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    uart_regif dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_done(tx_done), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic take_tx;
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
    endtask

    task automatic pulse_done;
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 irq", irq, 0);
        chk("R1 tx_valid", tx_valid, 0);
        chk("R1 rx_ready", rx_ready, 1);
        chk("R1 err", bus_err, 0);
        for (int i = 1; i < 8; i++)
            rd_chk("R1 reg", 8'(i * 4), (i == 5) ? 32'h20 : 32'h0);
        rd_chk("R1 rbuf", 8'h00, 32'h0);
    endtask

    task automatic t_plain;
        wr(8'h0C, 32'hFFFF_FFA5); rd_chk("R2 lctl", 8'h0C, 32'hA5);
        wr(8'h10, 32'h1234_565A); rd_chk("R2 mctl", 8'h10, 32'h5A);
        wr(8'h18, 32'h0000_003C); rd_chk("R2 mstat", 8'h18, 32'h3C);
        wr(8'h1C, 32'h8000_00C3); rd_chk("R2 div", 8'h1C, 32'hC3);
        wr(8'h08, 32'h0000_0181); rd_chk("R2 iid", 8'h08, 32'h81);
        wr(8'h08, 32'h0);
    endtask

    task automatic t_mask;
        logic [7:0] m;
        for (int c = 0; c < 4; c++) begin
            m = (c == 0) ? 8'h1F : (c == 1) ? 8'h3F : (c == 2) ? 8'h7F : 8'hFF;
            wr(8'h0C, 32'(c));
            wr(8'h08, 32'hFF);
            wr(8'h00, 32'hFFFF_FFE6);
            chk("R3 valid", tx_valid, 1);
            chk("R4 masked char", tx_data, 8'hE6 & m);
            rd_chk("R3 lstat", 8'h14, 32'h00);
            rd_chk("R3 iid", 8'h08, 32'hFD);
            take_tx;
            pulse_done;
            rd_chk("R6 lstat", 8'h14, 32'h20);
            rd_chk("R6 iid", 8'h08, 32'h02);
            chk("R6 irq off", irq, 0);
        end
    endtask

    task automatic t_handshake;
        wr(8'h00, 32'h41);
        repeat (4) @(negedge clk);
        chk("R5 held", tx_valid, 1);
        pulse_done;
        chk("R5 done early", tx_valid, 1);
        rd_chk("R5 lstat early", 8'h14, 32'h00);
        take_tx;
        chk("R5 taken", tx_valid, 0);
        rd_chk("R5 wait", 8'h14, 32'h00);
        pulse_done;
        rd_chk("R5 done", 8'h14, 32'h20);
        wr(8'h08, 32'h0);
        pulse_done;
        rd_chk("R5 idle done iid", 8'h08, 32'h00);
        chk("R5 idle done valid", tx_valid, 0);
    endtask

    task automatic t_tx_irq;
        wr(8'h00, 32'h55);
        wr(8'h04, 32'h02);
        chk("R7 no fire busy", irq, 0);
        take_tx;
        pulse_done;
        chk("R6 irq", irq, 1);
        rd_chk("R6 iid", 8'h08, 32'h02);
        wr(8'h04, 32'h00);
        chk("R7 clear", irq, 0);
        wr(8'h08, 32'h0);
        wr(8'h04, 32'h02);
        chk("R7 immediate", irq, 1);
        rd_chk("R7 iid", 8'h08, 32'h02);
        wr(8'h04, 32'h01);
        chk("R7 bit1 clear", irq, 0);
        wr(8'h04, 32'h00);
    endtask

    task automatic t_rx;
        wr(8'h08, 32'h0);
        wr(8'h04, 32'h01);
        @(negedge clk); rx_valid = 1'b1; rx_data = 8'h3C;
        @(negedge clk); rx_data = 8'h99;
        chk("R8 flag ready", rx_ready, 0);
        chk("R8 irq", irq, 1);
        repeat (2) @(negedge clk);
        rx_valid = 1'b0;
        rd_chk("R8 lstat", 8'h14, 32'h21);
        rd_chk("R8 iid", 8'h08, 32'h04);
        rd_chk("R9 rbuf", 8'h00, 32'h3C);
        rd_chk("R9 lstat", 8'h14, 32'h20);
        chk("R9 ready", rx_ready, 1);
        wr(8'h04, 32'h00);
        wr(8'h08, 32'h0);
        @(negedge clk); rx_valid = 1'b1; rx_data = 8'h5A;
        @(negedge clk); rx_valid = 1'b0;
        chk("R8 no irq", irq, 0);
        rd_chk("R8 iid kept", 8'h08, 32'h00);
        rd_chk("R9 rbuf2", 8'h00, 32'h5A);
    endtask

    task automatic t_pending;
        wr(8'h0C, 32'h3);
        wr(8'h00, 32'h11);
        chk("R11 first", tx_data, 8'h11);
        take_tx;
        wr(8'h00, 32'h22);
        chk("R11 not offered", tx_valid, 0);
        pulse_done;
        chk("R11 offered", tx_valid, 1);
        chk("R11 char", tx_data, 8'h22);
        rd_chk("R11 lstat", 8'h14, 32'h00);
        take_tx;
        pulse_done;
        rd_chk("R11 final", 8'h14, 32'h20);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        chk("R10 err before", bus_err, 0);
        wr(8'h0C, 32'h2);
        rd_chk("R10 read", 8'h20, 32'h0);
        chk("R10 err", bus_err, 1);
        wr(8'h0D, 32'hFF);
        wr(8'h2C, 32'hFF);
        rd_chk("R10 lctl kept", 8'h0C, 32'h2);
        rd(8'h04, v);
        chk("R10 sticky", bus_err, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: act=timeout exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_plain;
        t_mask;
        t_handshake;
        t_tx_irq;
        t_rx;
        t_pending;
        t_unmapped;
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule